// File: doc/BRIEF.md
# Isochronous Complete-Split Progress Checker

This block follows the complete-split phase of one periodic split IN transfer in a USB 2.0 host controller. Software, or the schedule walker, loads the transfer with a byte total and an 8-bit mask of the microframes in which complete-splits are planned. After that, the block is stepped once per microframe with a tick. The tick carries the low three frame-index bits and the transaction translator's reply to that microframe's complete-split. The reply is a response code, a payload byte count and a CRC/error flag.

On each scheduled tick the block first confirms that every earlier scheduled complete-split has actually run. It does this with an in-order progress vector, one bit per microframe. If an earlier one is missing, the block flags a missed microframe and retires the transfer. Otherwise it issues the complete-split, records it in the progress vector, subtracts the payload from the remaining count and decides whether to retire. Only translator responses retire the transfer. A remaining count of zero never does, so a translator that holds back its final status still gets polled.

Top module: `csplit_tracker`

## Requirements
- R1: A load strobe sets active to 1, sets remaining_bytes to load_bytes, stores load_mask, and clears the progress vector and both error flags. Load takes priority over a tick in the same cycle, and that tick is ignored.
- R2: A tick while active, whose uf_idx selects a set mask bit and whose earlier scheduled bits are all in the progress vector, makes issue_csplit high for exactly the one cycle after the tick. A tick on an unscheduled microframe issues nothing and changes nothing.
- R3: The progress bit at position uf_idx is set when a complete-split issues there. If any mask bit below uf_idx is set but its progress bit is clear, the tick issues nothing: missed_uframe_err goes to 1, active goes to 0 and done pulses.
- R4: When a complete-split issues with response code DATA (0) or MDATA (1), resp_bytes is subtracted from remaining_bytes, saturating at zero.
- R5: An MDATA response that is not on the last scheduled microframe leaves active at 1, even when remaining_bytes reaches zero.
- R6: A DATA response retires the transfer (active 0, done pulse). Later scheduled ticks issue nothing.
- R7: A DATA response with resp_err set, such as a CRC failure held back to the final complete-split, sets xact_err at retirement.
- R8: NYET (code 2) on a microframe with a higher scheduled bit changes nothing. NYET on the last scheduled microframe retires with xact_err set.
- R9: An error response (code 3) retires with xact_err set.
- R10: MDATA on the last scheduled microframe retires with xact_err set, because no final status can follow.
- R11: done is high for exactly one cycle per retirement. Ticks while inactive change no output.
- R12: After a synchronous reset, active, done, issue_csplit, missed_uframe_err and xact_err are 0 and remaining_bytes is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start-transfer strobe |
| load_bytes | input | BYTE_W | Byte total to expect |
| load_mask | input | NUF | Complete-split schedule mask |
| uf_tick | input | 1 | One microframe step with its response |
| uf_idx | input | IDX_W | Frame-index low bits of this microframe |
| resp_code | input | 2 | 0 DATA, 1 MDATA, 2 NYET, 3 error |
| resp_bytes | input | BYTE_W | Payload byte count of the response |
| resp_err | input | 1 | CRC/error flag with a DATA response |
| issue_csplit | output | 1 | Complete-split was issued in the previous tick |
| active | output | 1 | Transfer still live |
| done | output | 1 | Retirement pulse |
| missed_uframe_err | output | 1 | Skipped complete-split detected |
| xact_err | output | 1 | Transaction error status |
| remaining_bytes | output | BYTE_W | Bytes still expected |

## Verification
A load and a tick can fall in the same cycle. So can the skip check and the issue path, because both are decided by one tick. The bench drives load together with a scheduled tick and expects the load to win, with no issue pulse and the progress cleared. It also withholds random ticks inside a transfer so that a later scheduled tick finds a missing progress bit. There it expects missed_uframe_err with no issue_csplit in the same cycle, and a reference model built from the requirements judges every cycle.

// File: rtl/csplit_pkg.sv
package csplit_pkg;
  typedef enum logic [1:0] {
    RSP_DATA  = 2'd0,
    RSP_MDATA = 2'd1,
    RSP_NYET  = 2'd2,
    RSP_ERR   = 2'd3
  } rsp_e;
endpackage

// File: rtl/csplit_order_check.sv
module csplit_order_check #(
  parameter int NUF   = 8,
  parameter int IDX_W = $clog2(NUF)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [NUF-1:0]   mask,
  input  logic [NUF-1:0]   prog,
  output logic             sched,
  output logic             skip,
  output logic             last
);
  logic [NUF-1:0] below, above;

  for (genvar i = 0; i < NUF; i++) begin : g_pos
    assign below[i] = (IDX_W'(i) < idx);
    assign above[i] = (IDX_W'(i) > idx);
  end

  assign sched = mask[idx];
  assign skip  = |(mask & below & ~prog);
  assign last  = ~|(mask & above);
endmodule

// File: rtl/csplit_byte_counter.sv
module csplit_byte_counter #(
  parameter int BYTE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              sub_en,
  input  logic [BYTE_W-1:0] sub_val,
  output logic [BYTE_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (load)   count <= load_val;
    else if (sub_en) count <= (sub_val >= count) ? '0 : count - sub_val;
  end
endmodule

// File: rtl/csplit_tracker.sv
module csplit_tracker
  import csplit_pkg::*;
#(
  parameter int NUF    = 8,
  parameter int BYTE_W = 11,
  localparam int IDX_W = $clog2(NUF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_bytes,
  input  logic [NUF-1:0]    load_mask,
  input  logic              uf_tick,
  input  logic [IDX_W-1:0]  uf_idx,
  input  logic [1:0]        resp_code,
  input  logic [BYTE_W-1:0] resp_bytes,
  input  logic              resp_err,
  output logic              issue_csplit,
  output logic              active,
  output logic              done,
  output logic              missed_uframe_err,
  output logic              xact_err,
  output logic [BYTE_W-1:0] remaining_bytes
);
  logic [NUF-1:0] prog_q, mask_q;
  logic sched, skip, last;
  logic go, skip_hit, issue_now, sub_en, retire, err_now;
  rsp_e rsp;

  assign rsp = rsp_e'(resp_code);

  csplit_order_check #(.NUF(NUF), .IDX_W(IDX_W)) u_order (
    .idx(uf_idx), .mask(mask_q), .prog(prog_q),
    .sched(sched), .skip(skip), .last(last)
  );

  always_comb begin
    go        = uf_tick && active && !load && sched;
    skip_hit  = go && skip;
    issue_now = go && !skip;
    sub_en    = issue_now && (rsp == RSP_DATA || rsp == RSP_MDATA);
    err_now   = 1'b0;
    retire    = skip_hit;
    if (issue_now) begin
      unique case (rsp)
        RSP_DATA:  begin retire = 1'b1; err_now = resp_err; end
        RSP_MDATA: begin retire = last; err_now = last;     end
        RSP_NYET:  begin retire = last; err_now = last;     end
        RSP_ERR:   begin retire = 1'b1; err_now = 1'b1;     end
        default:   ;
      endcase
    end
  end

  csplit_byte_counter #(.BYTE_W(BYTE_W)) u_bytes (
    .clk(clk), .rst(rst), .load(load), .load_val(load_bytes),
    .sub_en(sub_en), .sub_val(resp_bytes), .count(remaining_bytes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q            <= '0;
      mask_q            <= '0;
      active            <= 1'b0;
      done              <= 1'b0;
      issue_csplit      <= 1'b0;
      missed_uframe_err <= 1'b0;
      xact_err          <= 1'b0;
    end else begin
      issue_csplit <= issue_now;
      done         <= retire;
      if (load) begin
        prog_q            <= '0;
        mask_q            <= load_mask;
        active            <= 1'b1;
        missed_uframe_err <= 1'b0;
        xact_err          <= 1'b0;
      end else begin
        if (issue_now) prog_q[uf_idx] <= 1'b1;
        if (retire)    active <= 1'b0;
        if (skip_hit)  missed_uframe_err <= 1'b1;
        if (err_now)   xact_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/csplit_tracker_chk.sv
module csplit_tracker_chk #(
  parameter int BYTE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [BYTE_W-1:0] load_bytes,
  input logic              uf_tick,
  input logic              issue_csplit,
  input logic              active,
  input logic              done,
  input logic              missed_uframe_err,
  input logic              xact_err,
  input logic [BYTE_W-1:0] remaining_bytes
);
  // R1
  load_init_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (active && remaining_bytes == $past(load_bytes) && !xact_err && !missed_uframe_err && !issue_csplit));
  // R2
  issue_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    issue_csplit |-> ($past(uf_tick) && $past(active) && active == !done));
  // R3
  miss_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(missed_uframe_err) |-> (!issue_csplit && done));
  // R4
  bytes_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> (remaining_bytes <= $past(remaining_bytes)));
  // R11
  done_retire_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!active && $past(active) && $past(uf_tick)));
endmodule

bind csplit_tracker csplit_tracker_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .load_bytes(load_bytes), .uf_tick(uf_tick),
  .issue_csplit(issue_csplit), .active(active), .done(done),
  .missed_uframe_err(missed_uframe_err), .xact_err(xact_err),
  .remaining_bytes(remaining_bytes)
);

// File: tb/sim_csplit_tracker.sv
`timescale 1ns/1ps
module sim_csplit_tracker;
  localparam int NUF = 8;
  localparam int BW  = 11;

  logic clk = 1'b0, rst = 1'b1, load = 1'b0, uf_tick = 1'b0, resp_err = 1'b0;
  logic [BW-1:0] load_bytes = '0, resp_bytes = '0;
  logic [NUF-1:0] load_mask = '0;
  logic [2:0] uf_idx = '0;
  logic [1:0] resp_code = '0;
  logic issue_csplit, active, done, missed_uframe_err, xact_err;
  logic [BW-1:0] remaining_bytes;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference state
  bit m_active, m_miss, m_xerr, m_issue, m_done;
  int m_rem;
  logic [7:0] m_prog, m_mask;

  always #5 clk = ~clk;

  csplit_tracker #(.NUF(NUF), .BYTE_W(BW)) u0 (
    .clk(clk), .rst(rst), .load(load), .load_bytes(load_bytes), .load_mask(load_mask),
    .uf_tick(uf_tick), .uf_idx(uf_idx), .resp_code(resp_code), .resp_bytes(resp_bytes),
    .resp_err(resp_err), .issue_csplit(issue_csplit), .active(active), .done(done),
    .missed_uframe_err(missed_uframe_err), .xact_err(xact_err),
    .remaining_bytes(remaining_bytes)
  );

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " issue"}, int'(issue_csplit), int'(m_issue));
    chk({tag, " done"}, int'(done), int'(m_done));
    chk({tag, " active"}, int'(active), int'(m_active));
    chk({tag, " miss"}, int'(missed_uframe_err), int'(m_miss));
    chk({tag, " xerr"}, int'(xact_err), int'(m_xerr));
    chk({tag, " rem"}, int'(remaining_bytes), m_rem);
  endtask

  // reference of one tick, from the requirements
  function automatic void model_tick(int idx, int code, int nb, bit crc);
    logic [7:0] req, hi;
    m_issue = 0; m_done = 0;
    if (!m_active || !m_mask[idx]) return;
    req = m_mask & ((8'h1 << idx) - 8'h1);
    hi  = m_mask & ~((8'h2 << idx) - 8'h1);
    if ((req & ~m_prog) != 0) begin
      m_miss = 1; m_active = 0; m_done = 1; return;
    end
    m_issue = 1;
    m_prog[idx] = 1'b1;
    if (code <= 1) m_rem = (nb >= m_rem) ? 0 : m_rem - nb;
    case (code)
      0: begin m_active = 0; m_done = 1; if (crc) m_xerr = 1; end
      1, 2: if (hi == 0) begin m_active = 0; m_done = 1; m_xerr = 1; end
      default: begin m_active = 0; m_done = 1; m_xerr = 1; end
    endcase
  endfunction

  task automatic do_load(int nb, logic [7:0] msk, bit with_tick, int idx);
    load = 1; load_bytes = BW'(nb); load_mask = msk;
    uf_tick = with_tick; uf_idx = 3'(idx); resp_code = 2'd0; resp_bytes = '0; resp_err = 0;
    @(posedge clk); #1;
    load = 0; uf_tick = 0;
    m_active = 1; m_rem = nb; m_mask = msk; m_prog = '0;
    m_miss = 0; m_xerr = 0; m_issue = 0; m_done = 0;
  endtask

  task automatic do_tick(int idx, int code, int nb, bit crc);
    uf_tick = 1; uf_idx = 3'(idx); resp_code = 2'(code); resp_bytes = BW'(nb); resp_err = crc;
    @(posedge clk); #1;
    uf_tick = 0; resp_err = 0;
    model_tick(idx, code, nb, crc);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    m_issue = 0; m_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1; rst = 0;
    m_active = 0; m_rem = 0; m_miss = 0; m_xerr = 0; m_issue = 0; m_done = 0;
    m_prog = '0; m_mask = '0;
    check_all("R12 reset");

    // R5 + R7: MDATA drains to zero, stays active; DATA with CRC error retires
    do_load(100, 8'b0011_1100, 0, 0); check_all("R1 load");
    do_tick(2, 1, 100, 0); check_all("R5 mdata zero keeps active");
    do_tick(3, 0, 0, 1);   check_all("R7 data crc");
    do_tick(4, 1, 5, 0);   check_all("R6 no issue after retire");
    idle();                check_all("R11 done one cycle");

    // R1: load together with a tick, load wins
    do_load(50, 8'b0000_0011, 1, 0); check_all("R1 load beats tick");
    // R2 unscheduled tick, R8 NYET before last then on last
    do_tick(5, 1, 10, 0); check_all("R2 unscheduled tick");
    do_tick(0, 2, 0, 0);  check_all("R8 nyet early");
    do_tick(1, 2, 0, 0);  check_all("R8 nyet last");

    // R3 skip detection
    do_load(300, 8'b0001_1110, 0, 0);
    do_tick(1, 1, 20, 0); check_all("R2 issue");
    do_tick(3, 1, 20, 0); check_all("R3 skipped uframe");
    do_tick(4, 0, 20, 0); check_all("R11 tick while inactive");

    // R4 saturation, R9 error response, R10 MDATA on last
    do_load(10, 8'b0000_0110, 0, 0);
    do_tick(1, 1, 40, 0); check_all("R4 saturate");
    do_tick(2, 1, 0, 0);  check_all("R10 mdata last");
    do_load(10, 8'b0000_0110, 0, 0);
    do_tick(1, 3, 0, 0);  check_all("R9 error resp");

    // random transfers
    for (int t = 0; t < 400; t++) begin
      logic [7:0] msk;
      msk = 8'($urandom_range(1, 255));
      do_load($urandom_range(0, 1500), msk, ($urandom_range(0, 15) == 0), $urandom_range(0, 7));
      check_all("R1 random load");
      for (int u = 0; u < 8; u++) begin
        int r, code;
        if ($urandom_range(0, 9) == 0) begin
          idle(); check_all("R3 random gap");
          continue;
        end
        r = $urandom_range(0, 19);
        code = (r < 8) ? 1 : (r < 14) ? 2 : (r < 19) ? 0 : 3;
        do_tick(u, code, $urandom_range(0, 400), ($urandom_range(0, 5) == 0));
        check_all("R2 R4 R6 random tick");
      end
      idle(); check_all("R11 random tail");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule